// File: doc/BRIEF.md
# Asynchronous Serial Port Engine

This block is a full-duplex asynchronous serial transmitter and receiver with the behaviour of a classic microcontroller serial port. A one-cycle write strobe with a data byte starts a transmit frame at once. A receiver watches the incoming line and commits each received byte to a readable buffer. Both directions run from separate single-cycle ticks at 16 times the bit rate, supplied by an external baud generator. Every bit lasts sixteen of those ticks.

Each direction has a completion flag that stays set until software pulses the matching clear strobe. The transmit flag rises when the stop bit begins, not when it ends. A received byte is committed only when the previous one has been acknowledged (receive flag low). When the stop-check control is on, the received stop bit must also be high. A frame that fails these conditions leaves the buffer, the stop flag and the receive flag untouched. One interrupt request combines both flags behind an enable.

Top module: `async_serial_port`

## Requirements
- R1: A transmit frame on `txd` is a low start bit, then the data bits with bit 0 first, then a high stop bit. Each bit lasts OVERSAMPLE ticks of `tx_tick16`.
- R2: After reset `txd` is 1, `tx_done`, `rx_done` and `rx_stop_flag` are 0, and `rx_buf` is 0. Whenever no frame is being sent, `txd` is 1.
- R3: A `buf_wr` strobe while a transmit frame is in progress is ignored, and the frame in flight goes out unchanged.
- R4: `tx_done` rises in the cycle the stop bit starts on `txd`, and is still 0 during the last data bit.
- R5: A frame that arrives while `rx_enable` is 0 is not received, and `rx_done` stays 0.
- R6: A frame that completes while `rx_done` is 1 is discarded: `rx_buf`, `rx_stop_flag` and `rx_done` keep their values.
- R7: With `stop_check` at 1, a frame whose stop bit is 0 is discarded. With `stop_check` at 0 it is committed, and `rx_stop_flag` then reads 0. A committed frame sets `rx_stop_flag` to the received stop level.
- R8: Each received data and stop bit is the majority of three samples taken just before the bit center, so a disturbance that affects only one sample does not change the bit.
- R9: A low pulse on `rxd` that is high again at the middle of the start bit (8 ticks after the falling edge) is dropped without a commit. The receiver then accepts the next valid frame.
- R10: `tx_done` and `rx_done` stay set until their own clear strobe, `tx_done_clr` or `rx_done_clr`. Hardware never clears them, and a clear of one flag does not touch the other.
- R11: `irq` is 1 exactly when `irq_enable` is 1 and at least one of `tx_done` or `rx_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_tick16 | input | 1 | Transmit tick, 16x bit rate, one cycle wide |
| rx_tick16 | input | 1 | Receive tick, 16x bit rate, one cycle wide |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_BITS | Byte to transmit |
| rx_enable | input | 1 | Receiver enable |
| stop_check | input | 1 | Require stop bit 1 for commit |
| irq_enable | input | 1 | Interrupt enable |
| tx_done_clr | input | 1 | Clear strobe for tx_done |
| rx_done_clr | input | 1 | Clear strobe for rx_done |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_buf | output | DATA_BITS | Last committed received byte |
| rx_stop_flag | output | 1 | Stop bit of last committed frame |
| tx_done | output | 1 | Transmit-complete flag |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A table of bytes is sent both ways. It holds alternating, all-zero, all-one and single-set-bit patterns, so a swapped bit order, a stuck bit or an off-by-one bit count shows up. In the same table the stop level and the stop check are varied, which tells a committed frame from a rejected one and checks the stored stop level. Directed frames then carry glitches on one sample per bit, a runt start pulse, a frame sent while the receiver is disabled, and a frame that overruns an unacknowledged byte. Each of these changes the result only if the voting, start validation, enable gating or commit gate is wrong.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [1:0] {
      SP_IDLE  = 2'd0,
      SP_START = 2'd1,
      SP_DATA  = 2'd2,
      SP_STOP  = 2'd3
   } sp_phase_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_pass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sp_tx.sv
module sp_tx
   import sp_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] load_data,
   output logic                 line,
   output logic                 busy,
   output logic                 stop_begin
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_BITS + 1);
   localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_BITS - 1);

   sp_phase_e            phase;
   logic [CNT_W-1:0]     cnt;
   logic [IDX_W-1:0]     idx;
   logic [DATA_BITS-1:0] shreg;
   logic                 bit_end;

   assign bit_end    = tick && (cnt == LAST_TICK);
   assign stop_begin = (phase == SP_DATA) && bit_end && (idx == LAST_BIT);
   assign busy       = (phase != SP_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= SP_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
      end else if (phase == SP_IDLE) begin
         if (load) begin
            phase <= SP_START;
            cnt   <= '0;
            shreg <= load_data;
         end
      end else if (tick) begin
         cnt <= bit_end ? '0 : cnt + 1'b1;
         if (bit_end) begin
            case (phase)
               SP_START: begin
                  phase <= SP_DATA;
                  idx   <= '0;
               end
               SP_DATA: begin
                  shreg <= shreg >> 1;
                  if (idx == LAST_BIT) phase <= SP_STOP;
                  else                 idx   <= idx + 1'b1;
               end
               default: phase <= SP_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (phase)
         SP_START: line = 1'b0;
         SP_DATA:  line = shreg[0];
         default:  line = 1'b1;
      endcase
   end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
   import sp_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 enable,
   input  logic                 line,
   output logic                 frame_done,
   output logic [DATA_BITS-1:0] frame_data,
   output logic                 frame_stop
);
   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_BITS + 1);
   localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] VOTE_A    = CNT_W'(OVERSAMPLE - 3);
   localparam logic [CNT_W-1:0] VOTE_B    = CNT_W'(OVERSAMPLE - 2);
   localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_BITS - 1);

   sp_phase_e            phase;
   logic [CNT_W-1:0]     cnt;
   logic [IDX_W-1:0]     idx;
   logic [DATA_BITS-1:0] shreg;
   logic                 prev_line;
   logic [1:0]           votes;
   logic                 decide;
   logic                 vote;

   assign decide     = tick && (cnt == LAST_TICK) && (phase == SP_DATA || phase == SP_STOP);
   assign vote       = (votes[0] & votes[1]) | (votes[0] & line) | (votes[1] & line);
   assign frame_done = enable && decide && (phase == SP_STOP);
   assign frame_data = shreg;
   assign frame_stop = vote;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= SP_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         prev_line <= 1'b1;
         votes     <= '0;
      end else begin
         prev_line <= line;
         if (!enable) begin
            phase <= SP_IDLE;
         end else begin
            case (phase)
               SP_IDLE: begin
                  if (prev_line && !line) begin
                     phase <= SP_START;
                     cnt   <= '0;
                  end
               end
               SP_START: begin
                  if (tick) begin
                     if (cnt == MID_TICK) begin
                        cnt   <= '0;
                        idx   <= '0;
                        phase <= line ? SP_IDLE : SP_DATA;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: begin
                  if (tick) begin
                     cnt <= decide ? '0 : cnt + 1'b1;
                     if (cnt == VOTE_A) votes[0] <= line;
                     if (cnt == VOTE_B) votes[1] <= line;
                     if (decide) begin
                        if (phase == SP_DATA) begin
                           shreg <= {vote, shreg[DATA_BITS-1:1]};
                           if (idx == LAST_BIT) phase <= SP_STOP;
                           else                 idx   <= idx + 1'b1;
                        end else begin
                           phase <= SP_IDLE;
                        end
                     end
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port #(
   parameter int DATA_BITS   = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_tick16,
   input  logic                 rx_tick16,
   input  logic                 buf_wr,
   input  logic [DATA_BITS-1:0] buf_wdata,
   input  logic                 rx_enable,
   input  logic                 stop_check,
   input  logic                 irq_enable,
   input  logic                 tx_done_clr,
   input  logic                 rx_done_clr,
   input  logic                 rxd,
   output logic                 txd,
   output logic [DATA_BITS-1:0] rx_buf,
   output logic                 rx_stop_flag,
   output logic                 tx_done,
   output logic                 rx_done,
   output logic                 irq
);
   generate
      if (DATA_BITS < 5 || DATA_BITS > 9) begin : g_bad_bits
         $error("DATA_BITS must lie between 5 and 9");
      end
      if (OVERSAMPLE < 8 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 8");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 0 and 4");
      end
   endgenerate

   logic                 rxd_s;
   logic                 tx_busy;
   logic                 tx_stop_begin;
   logic                 rx_frame_done;
   logic [DATA_BITS-1:0] rx_frame_data;
   logic                 rx_frame_stop;
   logic                 commit;

   sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
   );

   sp_tx #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tx_tick16), .load(buf_wr),
      .load_data(buf_wdata), .line(txd), .busy(tx_busy),
      .stop_begin(tx_stop_begin)
   );

   sp_rx #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(rx_tick16), .enable(rx_enable),
      .line(rxd_s), .frame_done(rx_frame_done), .frame_data(rx_frame_data),
      .frame_stop(rx_frame_stop)
   );

   assign commit = rx_frame_done && !rx_done && (!stop_check || rx_frame_stop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf       <= '0;
         rx_stop_flag <= 1'b0;
         rx_done      <= 1'b0;
         tx_done      <= 1'b0;
      end else begin
         if (commit) begin
            rx_buf       <= rx_frame_data;
            rx_stop_flag <= rx_frame_stop;
            rx_done      <= 1'b1;
         end else if (rx_done_clr) begin
            rx_done <= 1'b0;
         end
         if (tx_stop_begin)    tx_done <= 1'b1;
         else if (tx_done_clr) tx_done <= 1'b0;
      end
   end

   assign irq = irq_enable && (tx_done || rx_done);
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 txd,
   input logic                 tx_busy,
   input logic                 tx_done,
   input logic                 tx_done_clr,
   input logic                 rx_done,
   input logic                 rx_done_clr,
   input logic [DATA_BITS-1:0] rx_buf,
   input logic                 rx_stop_flag,
   input logic                 rx_enable,
   input logic                 stop_check,
   input logic                 irq_enable,
   input logic                 irq
);
   assert_txd_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   assert_tx_done_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> (txd && tx_busy));

   assert_rx_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(rx_enable));

   assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rx_done_clr) |=> (rx_done && $stable(rx_buf) && $stable(rx_stop_flag)));

   assert_stop_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_done) && $past(stop_check)) |-> rx_stop_flag);

   assert_tx_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !tx_done_clr) |=> tx_done);

   assert_irq_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_enable |-> !irq);

   assert_irq_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_enable && rx_done) |-> irq);
endmodule

bind async_serial_port sp_checker #(.DATA_BITS(DATA_BITS)) u_sp_checker (
   .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
   .tx_done(tx_done), .tx_done_clr(tx_done_clr), .rx_done(rx_done),
   .rx_done_clr(rx_done_clr), .rx_buf(rx_buf), .rx_stop_flag(rx_stop_flag),
   .rx_enable(rx_enable), .stop_check(stop_check), .irq_enable(irq_enable),
   .irq(irq)
);

// File: tb/tb_async_serial_port.sv
module tb_async_serial_port;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 2;
   localparam int BIT_CYC    = 16 * TICK_DIV;
   localparam int NVEC       = 8;
   // fields: {expect_commit, stop_check, stop_level, data[7:0]}
   localparam logic [10:0] VECS [NVEC] = '{
      {1'b1, 1'b0, 1'b1, 8'hA5}, {1'b1, 1'b1, 1'b1, 8'h3C},
      {1'b1, 1'b0, 1'b1, 8'h00}, {1'b1, 1'b0, 1'b1, 8'hFF},
      {1'b1, 1'b0, 1'b0, 8'h81}, {1'b0, 1'b1, 1'b0, 8'h5A},
      {1'b1, 1'b1, 1'b1, 8'h01}, {1'b1, 1'b0, 1'b1, 8'h80}
   };

   logic clk = 0, rst_n = 0, tick = 0;
   logic buf_wr = 0, rx_enable = 1, stop_check = 0, irq_enable = 1;
   logic tx_done_clr = 0, rx_done_clr = 0, rxd = 1;
   logic [7:0] buf_wdata = '0;
   logic txd, rx_stop_flag, tx_done, rx_done, irq;
   logic [7:0] rx_buf;
   int checks = 0, failures = 0, tick_cnt = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) begin
      tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
      tick     <= (tick_cnt == TICK_DIV - 1);
   end

   async_serial_port dut (
      .clk(clk), .rst_n(rst_n), .tx_tick16(tick), .rx_tick16(tick),
      .buf_wr(buf_wr), .buf_wdata(buf_wdata), .rx_enable(rx_enable),
      .stop_check(stop_check), .irq_enable(irq_enable),
      .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr), .rxd(rxd),
      .txd(txd), .rx_buf(rx_buf), .rx_stop_flag(rx_stop_flag),
      .tx_done(tx_done), .rx_done(rx_done), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_rx();
      rx_done_clr = 1; @(negedge clk); rx_done_clr = 0;
   endtask

   task automatic send_rx(input logic [7:0] d, input logic stopv, input int ga, input int gb);
      rxd = 0; repeat (BIT_CYC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         for (int c = 0; c < BIT_CYC; c++) begin
            rxd = ((i == ga || i == gb) && (c == 16 || c == 17)) ? ~d[i] : d[i];
            @(negedge clk);
         end
      end
      rxd = stopv; repeat (BIT_CYC) @(negedge clk);
      rxd = 1;     repeat (8) @(negedge clk);
   endtask

   task automatic tx_check(input logic [7:0] d, input int inject_at);
      int n = 0;
      bit seen = 0;
      tx_done_clr = 1; buf_wr = 1; buf_wdata = d; @(negedge clk);
      tx_done_clr = 0; buf_wr = 0;
      while (txd && n < 100) begin @(negedge clk); n++; end
      repeat (15) @(negedge clk);
      chk("R1 start bit low", txd, 0);
      for (int i = 0; i < 8; i++) begin
         if (i == inject_at) begin
            buf_wr = 1; buf_wdata = ~d; @(negedge clk); buf_wr = 0;
            repeat (BIT_CYC - 1) @(negedge clk);
            chk("R3 write during frame ignored", txd, d[i]);
         end else begin
            repeat (BIT_CYC) @(negedge clk);
            chk("R1 data bit", txd, d[i]);
         end
      end
      chk("R4 tx_done not before stop", tx_done, 0);
      n = 0;
      while (!seen && n < 2 * BIT_CYC) begin
         @(negedge clk); n++;
         if (tx_done) seen = 1;
      end
      chk("R4 tx_done rises", seen, 1);
      chk("R4 stop bit high at tx_done", txd, 1);
      repeat (BIT_CYC + 8) @(negedge clk);
      chk("R2 idle line high", txd, 1);
   endtask

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk("R2 reset txd", txd, 1);
      chk("R2 reset tx_done", tx_done, 0);
      chk("R2 reset rx_done", rx_done, 0);
      chk("R2 reset rx_buf", rx_buf, 0);
      chk("R2 reset rx_stop_flag", rx_stop_flag, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);

      held = 8'h00;
      for (int v = 0; v < NVEC; v++) begin
         tx_check(VECS[v][7:0], -1);
         clear_rx();
         stop_check = VECS[v][9];
         send_rx(VECS[v][7:0], VECS[v][8], -1, -1);
         if (VECS[v][10]) begin
            held = VECS[v][7:0];
            chk("R1 R7 rx data committed", rx_buf, held);
            chk("R7 rx_stop_flag level", rx_stop_flag, VECS[v][8]);
            chk("R7 rx_done set", rx_done, 1);
         end else begin
            chk("R7 stop check rejects", rx_done, 0);
            chk("R7 rx_buf kept on reject", rx_buf, held);
         end
         stop_check = 0;
      end

      // R3: write in the middle of a frame
      tx_check(8'h3C, 3);

      // R10 and R11: flags persist and feed irq
      tx_check(8'h11, -1);
      clear_rx();
      send_rx(8'h6E, 1, -1, -1);
      repeat (300) @(negedge clk);
      chk("R10 tx_done persists", tx_done, 1);
      chk("R10 rx_done persists", rx_done, 1);
      irq_enable = 0; @(negedge clk);
      chk("R11 irq masked", irq, 0);
      irq_enable = 1; @(negedge clk);
      chk("R11 irq raised", irq, 1);
      clear_rx(); @(negedge clk);
      chk("R10 rx clear leaves tx_done", tx_done, 1);
      chk("R10 rx_done cleared", rx_done, 0);
      chk("R11 irq from tx_done", irq, 1);
      tx_done_clr = 1; @(negedge clk); tx_done_clr = 0; @(negedge clk);
      chk("R10 tx_done cleared", tx_done, 0);
      chk("R11 irq low with no flags", irq, 0);

      // R6: overrun keeps previous byte
      send_rx(8'hC9, 1, -1, -1);
      chk("R6 first byte stored", rx_buf, 8'hC9);
      send_rx(8'h24, 0, -1, -1);
      chk("R6 overrun keeps rx_buf", rx_buf, 8'hC9);
      chk("R6 overrun keeps rx_stop_flag", rx_stop_flag, 1);
      chk("R6 rx_done still set", rx_done, 1);

      // R5: receiver disabled
      clear_rx();
      rx_enable = 0;
      send_rx(8'h77, 1, -1, -1);
      chk("R5 disabled receiver ignores frame", rx_done, 0);
      chk("R5 rx_buf unchanged", rx_buf, 8'hC9);
      rx_enable = 1; repeat (4) @(negedge clk);

      // R9: runt start pulse, then a good frame
      rxd = 0; repeat (6) @(negedge clk);
      rxd = 1; repeat (3 * BIT_CYC) @(negedge clk);
      chk("R9 runt start dropped", rx_done, 0);
      send_rx(8'h96, 1, -1, -1);
      chk("R9 next frame accepted", rx_buf, 8'h96);

      // R8: single-sample glitches in two data bits
      clear_rx();
      send_rx(8'hC3, 1, 2, 5);
      chk("R8 majority vote outvotes glitch", rx_buf, 8'hC3);
      chk("R8 frame committed", rx_done, 1);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule